// File: doc/BRIEF.md
# Counter gate source selector

This block produces the gate level for each channel in one group of three counter channels. Every channel holds its own 5-bit source code. The code picks the channel's gate from one of these sources:

- a fixed high or low level;
- the channel's own gate pin, true or inverted;
- a counter output taken two places earlier in a ring that runs through the preceding group, true or inverted;
- a pattern-present level;
- two sticky flags that follow a pattern appearing and then going away.

For each channel the block also tells the pad logic whether the gate pin is an input or is driven as an output.

Software-side logic writes the codes one channel at a time through a simple write strobe. A separate clear strobe re-arms the two pattern flags. All inputs and outputs are plain level signals. No data stream passes through the block, so it has no valid/ready handshake and it never applies back-pressure.

Top module: `cgate_select`

## Requirements
- R1: After reset every channel code is 0, so every gate_out bit is 1 and every gate_pin_oe bit is 1. The occurred flag resets low and the gone-away flag resets high.
- R2: Code 0 holds the channel's gate at 1. Code 1 holds it at 0.
- R3: Code 2 passes gate_pin_in[n] to gate_out[n] and is the only code that drives gate_pin_oe[n] to 0. Every other code drives it to 1.
- R4: Code 3 gives the inverted ring source. Code 7 gives the ring source uninverted. The ring source of channel 2 is cnt_out_cur[0]. The ring source of channel 0 is cnt_out_prev[1], and that of channel 1 is cnt_out_prev[2].
- R5: Code 6 gives the inverse of gate_pin_in[n].
- R6: Code 8 gives pat_present. Code 11 gives its inverse.
- R7: Code 9 gives the occurred flag and code 12 gives its inverse. The flag becomes 1 at the first rising edge that samples pat_present high. It then stays 1 until a clear.
- R8: Code 10 gives the gone-away flag and code 13 gives its inverse. The flag falls to 0 at a rising edge that samples pat_present low while the occurred flag is already 1. It then stays 0 until a clear.
- R9: Codes 4, 5 and 14 through 31 are reserved and hold the gate at 0.
- R10: A write with cfg_we high stores cfg_code into channel cfg_chan at that rising edge, and the new code acts from the following cycle. A write with cfg_chan of 3 or more changes no code.
- R11: pat_clr sets the occurred flag to 0 and the gone-away flag to 1 at the rising edge. When both are asserted in the same cycle, the clear takes priority over a pattern sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Code write strobe |
| cfg_chan | input | 2 | Channel selected by the write |
| cfg_code | input | 5 | Gate source code to store |
| pat_clr | input | 1 | Re-arm strobe for the pattern flags |
| pat_present | input | 1 | Pattern-present level |
| gate_pin_in | input | 3 | Dedicated gate pin level, one bit per channel |
| cnt_out_cur | input | 3 | Counter outputs of this group |
| cnt_out_prev | input | 3 | Counter outputs of the preceding group |
| gate_out | output | 3 | Selected gate level, one bit per channel |
| gate_pin_oe | output | 3 | 1 when the channel's gate pin is driven as an output |

## Verification
gate_out and gate_pin_oe are combinational in the stored codes, the two flags and the present inputs. A change on a pin, a counter output or pat_present therefore shows in the same cycle. A code write or a flag update shows only after one rising edge.

The bench drives inputs on the falling edge and samples 5 ns later, before the next rising edge. Each task consumes exactly one rising edge. At that edge the bench applies its own flag and code update, so every expected value corresponds to the state the design holds during the sampled cycle.

// File: rtl/cgate_select_pkg.sv
`timescale 1ns/1ps
package cgate_select_pkg;
  localparam int CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    GS_ON     = 5'd0,
    GS_OFF    = 5'd1,
    GS_PIN    = 5'd2,
    GS_RING_N = 5'd3,
    GS_PIN_N  = 5'd6,
    GS_RING   = 5'd7,
    GS_PAT    = 5'd8,
    GS_OCC    = 5'd9,
    GS_GONE   = 5'd10,
    GS_PAT_N  = 5'd11,
    GS_OCC_N  = 5'd12,
    GS_GONE_N = 5'd13
  } gsrc_e;
endpackage

// File: rtl/cgate_code_bank.sv
`timescale 1ns/1ps
module cgate_code_bank
  import cgate_select_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int CH_AW = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [CH_AW-1:0]              chan,
  input  logic [CODE_W-1:0]             code_in,
  output logic [NCH-1:0][CODE_W-1:0]    codes
);
  // One register per channel; a write to an address past the last channel hits no slot.
  for (genvar k = 0; k < NCH; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        codes[k] <= GS_ON;
      else if (we && (chan == CH_AW'(k)))
        codes[k] <= code_in;
    end
  end
endmodule

// File: rtl/cgate_pattern_flags.sv
`timescale 1ns/1ps
module cgate_pattern_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pat,
  output logic occ,
  output logic gone
);
  // occ: sticky set while the pattern is seen.
  // gone: high until the pattern leaves after having been seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ  <= 1'b0;
      gone <= 1'b1;
    end else if (clr) begin
      occ  <= 1'b0;
      gone <= 1'b1;
    end else begin
      if (pat)
        occ <= 1'b1;
      if (occ && !pat)
        gone <= 1'b0;
    end
  end
endmodule

// File: rtl/cgate_chan_mux.sv
`timescale 1ns/1ps
module cgate_chan_mux
  import cgate_select_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic              pin,
  input  logic              ring,
  input  logic              pat,
  input  logic              occ,
  input  logic              gone,
  output logic              gate,
  output logic              pin_oe
);
  always_comb begin
    case (code)
      GS_ON:     gate = 1'b1;
      GS_OFF:    gate = 1'b0;
      GS_PIN:    gate = pin;
      GS_PIN_N:  gate = ~pin;
      GS_RING:   gate = ring;
      GS_RING_N: gate = ~ring;
      GS_PAT:    gate = pat;
      GS_PAT_N:  gate = ~pat;
      GS_OCC:    gate = occ;
      GS_OCC_N:  gate = ~occ;
      GS_GONE:   gate = gone;
      GS_GONE_N: gate = ~gone;
      default:   gate = 1'b0;
    endcase
  end

  // The pin is only an input when the channel listens to it directly.
  assign pin_oe = (code != GS_PIN);
endmodule

// File: rtl/cgate_select.sv
`timescale 1ns/1ps
module cgate_select
  import cgate_select_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int CH_AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_AW-1:0]  cfg_chan,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              pat_clr,
  input  logic              pat_present,
  input  logic [NCH-1:0]    gate_pin_in,
  input  logic [NCH-1:0]    cnt_out_cur,
  input  logic [NCH-1:0]    cnt_out_prev,
  output logic [NCH-1:0]    gate_out,
  output logic [NCH-1:0]    gate_pin_oe
);
  localparam int RING_LAG = 2;

  logic [NCH-1:0][CODE_W-1:0] chan_code;
  logic                       pat_occ;
  logic                       pat_gone;
  logic [NCH-1:0]             ring_src;

  cgate_code_bank #(.NCH(NCH), .CH_AW(CH_AW)) u_codes (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .chan    (cfg_chan),
    .code_in (cfg_code),
    .codes   (chan_code)
  );

  cgate_pattern_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pat_clr),
    .pat   (pat_present),
    .occ   (pat_occ),
    .gone  (pat_gone)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    // Channel n listens to channel n-2, wrapping into the preceding group.
    if (n >= RING_LAG) begin : g_local
      assign ring_src[n] = cnt_out_cur[n-RING_LAG];
    end else begin : g_wrap
      assign ring_src[n] = cnt_out_prev[n+NCH-RING_LAG];
    end

    cgate_chan_mux u_mux (
      .code   (chan_code[n]),
      .pin    (gate_pin_in[n]),
      .ring   (ring_src[n]),
      .pat    (pat_present),
      .occ    (pat_occ),
      .gone   (pat_gone),
      .gate   (gate_out[n]),
      .pin_oe (gate_pin_oe[n])
    );
  end
endmodule

// File: rtl/cgate_select_chk.sv
`timescale 1ns/1ps
module cgate_select_chk
  import cgate_select_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int CH_AW = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [CH_AW-1:0]           cfg_chan,
  input logic [CODE_W-1:0]          cfg_code,
  input logic                       pat_clr,
  input logic                       pat_present,
  input logic [NCH-1:0][CODE_W-1:0] chan_code,
  input logic                       pat_occ,
  input logic                       pat_gone
);
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(chan_code)); // R10

  for (genvar k = 0; k < NCH; k++) begin : g_load
    AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_chan == CH_AW'(k)) |=> chan_code[k] == $past(cfg_code)); // R10
  end

  AST_OCC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_present && !pat_clr) |=> pat_occ); // R7

  AST_OCC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_occ && !pat_clr) |=> pat_occ); // R7

  AST_GONE_AFTER_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pat_gone) |-> ($past(pat_occ) && !$past(pat_present))); // R8

  AST_GONE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pat_gone) |-> $past(pat_clr)); // R8

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pat_clr |=> (!pat_occ && pat_gone)); // R11
endmodule

bind cgate_select cgate_select_chk #(.NCH(NCH), .CH_AW(CH_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_chan    (cfg_chan),
  .cfg_code    (cfg_code),
  .pat_clr     (pat_clr),
  .pat_present (pat_present),
  .chan_code   (chan_code),
  .pat_occ     (pat_occ),
  .pat_gone    (pat_gone)
);

// File: tb/cgate_select_test.sv
`timescale 1ns/1ps
module cgate_select_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_chan = '0;
  logic [4:0] cfg_code = '0;
  logic       pat_clr = 1'b0;
  logic       pat_present = 1'b0;
  logic [2:0] gate_pin_in = '0;
  logic [2:0] cnt_out_cur = '0;
  logic [2:0] cnt_out_prev = '0;
  logic [2:0] gate_out;
  logic [2:0] gate_pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model state
  bit m_occ = 0;
  bit m_gone = 1;
  int m_code [3] = '{0, 0, 0};

  always #10 clk = ~clk;

  cgate_select uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_code(cfg_code), .pat_clr(pat_clr), .pat_present(pat_present),
    .gate_pin_in(gate_pin_in), .cnt_out_cur(cnt_out_cur),
    .cnt_out_prev(cnt_out_prev), .gate_out(gate_out), .gate_pin_oe(gate_pin_oe)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int code);
    case (code)
      0, 1:   return "R2";
      2:      return "R3";
      3, 7:   return "R4";
      6:      return "R5";
      8, 11:  return "R6";
      9, 12:  return "R7";
      10, 13: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic bit exp_gate(input int ch, input int code);
    bit ring;
    ring = (ch >= 2) ? cnt_out_cur[ch-2] : cnt_out_prev[ch+1];
    case (code)
      0: return 1'b1;
      1: return 1'b0;
      2: return gate_pin_in[ch];
      3: return !ring;
      6: return !gate_pin_in[ch];
      7: return ring;
      8: return pat_present;
      9: return m_occ;
      10: return m_gone;
      11: return !pat_present;
      12: return !m_occ;
      13: return !m_gone;
      default: return 1'b0;
    endcase
  endfunction

  // flag update at a rising edge, from R7, R8, R11
  task automatic model_edge(input bit pt, input bit cl);
    bit ng;
    if (cl) begin
      m_occ = 0; m_gone = 1;
    end else begin
      ng = (m_occ && !pt) ? 1'b0 : m_gone;
      if (pt) m_occ = 1;
      m_gone = ng;
    end
  endtask

  task automatic check_all();
    for (int ch = 0; ch < 3; ch++) begin
      chk(tag_of(m_code[ch]), 3'(gate_out[ch]), 3'(exp_gate(ch, m_code[ch])));
      chk("R3", 3'(gate_pin_oe[ch]), 3'(m_code[ch] != 2));
    end
  endtask

  task automatic step(input logic [2:0] p, input logic [2:0] c, input logic [2:0] pv,
                      input logic pt, input logic cl);
    @(negedge clk);
    cfg_we = 0; gate_pin_in = p; cnt_out_cur = c; cnt_out_prev = pv;
    pat_present = pt; pat_clr = cl;
    #5;
    check_all();
    @(posedge clk);
    model_edge(pt, cl);
  endtask

  task automatic wr(input int ch, input int code);
    @(negedge clk);
    cfg_we = 1; cfg_chan = 2'(ch); cfg_code = 5'(code); pat_clr = 0;
    @(posedge clk);
    model_edge(pat_present, 0);
    if (ch < 3) m_code[ch] = code;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    // R1: reset state
    @(negedge clk); #5;
    chk("R1", gate_out, 3'b111);
    chk("R1", gate_pin_oe, 3'b111);
    @(posedge clk);
    model_edge(pat_present, 0);

    // R10: write to a channel past the end is ignored
    wr(3, 1);
    @(negedge clk); cfg_we = 0; #5;
    chk("R10", gate_out, 3'b111);
    @(posedge clk); model_edge(pat_present, 0);
    // R10: a valid write acts the next cycle
    wr(1, 1);
    @(negedge clk); cfg_we = 0; #5;
    chk("R10", gate_out, 3'b101);
    @(posedge clk); model_edge(pat_present, 0);

    // R1: flag reset values seen through codes 9 and 10
    wr(0, 9); wr(1, 10); wr(2, 13);
    @(negedge clk); cfg_we = 0; #5;
    chk("R1", gate_out, 3'b010);
    @(posedge clk); model_edge(pat_present, 0);

    // R7 / R8 sequence: pattern appears, then leaves
    step(3'b000, 3'b000, 3'b000, 1'b1, 1'b0);
    step(3'b000, 3'b000, 3'b000, 1'b1, 1'b0);
    @(negedge clk); pat_present = 0; #5;
    chk("R7", 3'(gate_out[0]), 3'd1);
    chk("R8", 3'(gate_out[1]), 3'd1);
    @(posedge clk); model_edge(0, 0);
    @(negedge clk); #5;
    chk("R8", gate_out, 3'b101);
    @(posedge clk); model_edge(0, 0);
    step(3'b000, 3'b000, 3'b000, 1'b1, 1'b0);
    chk("R8", 3'(m_gone), 3'd0);
    // R11: clear beats a pattern in the same cycle
    step(3'b000, 3'b000, 3'b000, 1'b1, 1'b1);
    @(negedge clk); pat_present = 0; pat_clr = 0; #5;
    chk("R11", gate_out, 3'b010);
    @(posedge clk); model_edge(0, 0);

    // sweep of every code on every channel with all input combinations
    for (int c = 0; c < 32; c++) begin
      wr(0, c); wr(1, (c + 5) % 32); wr(2, (c + 11) % 32);
      step(3'b000, 3'b000, 3'b000, 1'b0, 1'b1);
      for (int v = 0; v < 1024; v++) begin
        logic [9:0] b;
        b = 10'(v);
        step(b[3:1], b[6:4], b[9:7], b[0], 1'b0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule